// File: doc/BRIEF.md
# Compact Halfword Decode-Execute Unit

This block decodes and executes one 16-bit instruction per cycle from a small subset of a fixed-length RISC instruction set. It holds sixteen 32-bit general registers and a 32-bit status word. The status word carries a privilege bit (bit 30, set means supervisor) and a condition bit T (bit 0). The caller presents an instruction halfword together with the address it came from. The unit updates the registers or the status word at the next clock edge.

Supported operations are register copy, sign-extended byte immediate load, bitwise OR, shift-left by one that sets T, the two privileged transfers between the status word and a register, and a longword load addressed relative to the instruction address. The load goes through a synchronous read port whose data comes back one cycle after the request. During that cycle the unit reports busy and ignores its instruction input. Unknown encodings raise an illegal flag. Privileged transfers attempted with the privilege bit clear raise a reserved flag. Neither flagged case changes any state. A read-only peek port and the status output make the architectural state visible.

Top module: `cdx_core`

## Requirements
- R1: After reset every general register reads 0, the status output reads 0x4000_0000, and busy, rd_req, ill_flag and resv_flag are low.
- R2: Encoding 0x6nm3 writes register m into register n (n = bits 11:8, m = bits 7:4).
- R3: Encoding 0xEnii writes the byte ii (bits 7:0), sign-extended to 32 bits, into register n.
- R4: Encoding 0x2nmB writes the bitwise OR of registers n and m into register n.
- R5: Encoding 0x4n00 shifts register n left by one bit. Status bit 0 (T) takes the old bit 31 of register n and is cleared if that bit was 0. No other status bit changes.
- R6: Encoding 0x0n02 with status bit 30 set copies the status word into register n.
- R7: Encoding 0x4n0E with status bit 30 set loads the status word from register n.
- R8: With status bit 30 clear, the encodings 0x0n02 and 0x4n0E assert resv_flag in their decode cycle and change no register and no status bit.
- R9: Encoding 0x0009 does nothing and raises no flag. Encoding 0x0n09 with n not 0 is illegal.
- R10: Every encoding not listed in R2 to R9 and R11 asserts ill_flag in its decode cycle and changes no register and no status bit. ill_flag and resv_flag are never high together.
- R11: Encoding 0xDndd asserts rd_req in its decode cycle with rd_addr = (pc with bits 1:0 cleared) + 4 + 4*dd, where dd is unsigned. Busy is high for exactly the following cycle. The rd_data sampled at the end of that cycle is written into register n.
- R12: While busy is high, insn_valid and insn have no effect, and rd_req, ill_flag and resv_flag stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn | input | 16 | Instruction halfword |
| pc | input | 32 | Address of the presented instruction |
| busy | output | 1 | Waiting for load data; input ignored |
| ill_flag | output | 1 | Presented encoding is not recognised |
| resv_flag | output | 1 | Privileged transfer refused |
| rd_req | output | 1 | Data read request |
| rd_addr | output | 32 | Data read address |
| rd_data | input | 32 | Read data, valid the cycle after rd_req |
| peek_idx | input | 4 | Register selected for observation |
| peek_data | output | 32 | Contents of the selected register |
| sr_out | output | 32 | Current status word |

## Verification
The properties assume that the requester honours the fixed one-cycle read latency, so rd_data is meaningful only in the busy cycle. They also assume that pc is an arbitrary value whose low bits the unit must discard. The stimulus drives every one of the 65536 halfwords once, with pc values whose two low bits vary. It returns load data only in the busy cycle and, in one directed case, keeps presenting an instruction during busy to show that it is dropped. The status word changes along the sweep whenever a loaded register clears the privilege bit, so both the accepted and the refused paths of the privileged transfers are reached.

// File: rtl/cdx_pkg.sv
package cdx_pkg;
   typedef enum logic [3:0] {
      K_NOP, K_STC, K_LDC, K_OR, K_SHL, K_MOV, K_MOVI, K_LDL, K_ILL
   } kind_t;

   typedef struct packed {
      kind_t      kind;
      logic [3:0] n;
      logic [3:0] m;
      logic [7:0] imm;
   } dec_t;
endpackage

// File: rtl/cdx_decode.sv
module cdx_decode
   import cdx_pkg::*;
(
   input  logic [15:0] insn,
   output dec_t        dec
);
   logic [3:0] major;
   logic [7:0] lo_byte;
   logic [3:0] lo_nib;

   assign major   = insn[15:12];
   assign lo_byte = insn[7:0];
   assign lo_nib  = insn[3:0];

   always_comb begin
      dec.n    = insn[11:8];
      dec.m    = insn[7:4];
      dec.imm  = lo_byte;
      dec.kind = K_ILL;
      unique case (major)
         4'h0: begin
            if (lo_byte == 8'h02)
               dec.kind = K_STC;
            else if (lo_byte == 8'h09 && insn[11:8] == 4'h0)
               dec.kind = K_NOP;
         end
         4'h2: if (lo_nib == 4'hB) dec.kind = K_OR;
         4'h4: begin
            if (lo_byte == 8'h00)
               dec.kind = K_SHL;
            else if (lo_byte == 8'h0E)
               dec.kind = K_LDC;
         end
         4'h6: if (lo_nib == 4'h3) dec.kind = K_MOV;
         4'hD: dec.kind = K_LDL;
         4'hE: dec.kind = K_MOVI;
         default: dec.kind = K_ILL;
      endcase
   end
endmodule

// File: rtl/cdx_regfile.sv
module cdx_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 16,
   localparam int AW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [AW-1:0]   ra_a,
   output logic [XLEN-1:0] rd_a,
   input  logic [AW-1:0]   ra_b,
   output logic [XLEN-1:0] rd_b,
   input  logic [AW-1:0]   ra_c,
   output logic [XLEN-1:0] rd_c
);
   logic [XLEN-1:0] bank [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank[i] <= '0;
         else if (we && waddr == AW'(i))
            bank[i] <= wdata;
      end
   end

   assign rd_a = bank[ra_a];
   assign rd_b = bank[ra_b];
   assign rd_c = bank[ra_c];
endmodule

// File: rtl/cdx_core.sv
module cdx_core
   import cdx_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int NREG      = 16,
   parameter int MD_BIT    = 30,
   parameter int T_BIT     = 0,
   parameter bit PRIV_GATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            insn_valid,
   input  logic [15:0]     insn,
   input  logic [XLEN-1:0] pc,
   output logic            busy,
   output logic            ill_flag,
   output logic            resv_flag,
   output logic            rd_req,
   output logic [XLEN-1:0] rd_addr,
   input  logic [XLEN-1:0] rd_data,
   input  logic [3:0]      peek_idx,
   output logic [XLEN-1:0] peek_data,
   output logic [XLEN-1:0] sr_out
);
   localparam int              AW     = $clog2(NREG);
   localparam logic [XLEN-1:0] SR_RST = XLEN'(1) << MD_BIT;

   if (NREG != 16) begin : g_bad_nreg
      $error("cdx_core: register fields are 4 bits, NREG must be 16");
   end
   if (XLEN < 10 || MD_BIT >= XLEN || T_BIT >= XLEN || MD_BIT == T_BIT) begin : g_bad_sr
      $error("cdx_core: status bit placement does not fit XLEN");
   end

   dec_t            dec;
   logic            busy_q;
   logic [AW-1:0]   pend_q;
   logic [XLEN-1:0] sr_q, sr_d;
   logic [XLEN-1:0] val_n, val_m;
   logic            we;
   logic [AW-1:0]   waddr;
   logic [XLEN-1:0] wdata;
   logic            priv_ok;
   logic            req;

   cdx_decode u_dec (
      .insn (insn),
      .dec  (dec)
   );

   cdx_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .ra_a  (dec.n[AW-1:0]),
      .rd_a  (val_n),
      .ra_b  (dec.m[AW-1:0]),
      .rd_b  (val_m),
      .ra_c  (peek_idx[AW-1:0]),
      .rd_c  (peek_data)
   );

   if (PRIV_GATE) begin : g_priv
      assign priv_ok = sr_q[MD_BIT];
   end else begin : g_nopriv
      assign priv_ok = 1'b1;
   end

   always_comb begin
      we        = 1'b0;
      waddr     = dec.n[AW-1:0];
      wdata     = '0;
      sr_d      = sr_q;
      ill_flag  = 1'b0;
      resv_flag = 1'b0;
      req       = 1'b0;
      if (busy_q) begin
         we    = 1'b1;
         waddr = pend_q;
         wdata = rd_data;
      end else if (insn_valid) begin
         unique case (dec.kind)
            K_MOV: begin
               we    = 1'b1;
               wdata = val_m;
            end
            K_MOVI: begin
               we    = 1'b1;
               wdata = {{(XLEN-8){dec.imm[7]}}, dec.imm};
            end
            K_OR: begin
               we    = 1'b1;
               wdata = val_n | val_m;
            end
            K_SHL: begin
               we          = 1'b1;
               wdata       = val_n << 1;
               sr_d[T_BIT] = val_n[XLEN-1];
            end
            K_STC: begin
               if (priv_ok) begin
                  we    = 1'b1;
                  wdata = sr_q;
               end else begin
                  resv_flag = 1'b1;
               end
            end
            K_LDC: begin
               if (priv_ok) sr_d = val_n;
               else         resv_flag = 1'b1;
            end
            K_LDL:   req      = 1'b1;
            K_ILL:   ill_flag = 1'b1;
            default: ;
         endcase
      end
   end

   assign rd_addr = (pc & ~XLEN'(3)) + XLEN'(4) + XLEN'({dec.imm, 2'b00});
   assign rd_req  = req;
   assign busy    = busy_q;
   assign sr_out  = sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= '0;
         sr_q   <= SR_RST;
      end else begin
         busy_q <= req;
         sr_q   <= sr_d;
         if (req) pend_q <= dec.n[AW-1:0];
      end
   end
endmodule

// File: rtl/cdx_core_chk.sv
module cdx_core_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            ill_flag,
   input logic            resv_flag,
   input logic            rd_req,
   input logic [XLEN-1:0] rd_addr,
   input logic [XLEN-1:0] sr_out
);
   p_req_then_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> busy);
   p_busy_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);
   p_addr_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> rd_addr[1:0] == 2'b00);
   p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ill_flag && resv_flag));
   p_ill_keeps_sr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ill_flag |=> $stable(sr_out));
   p_resv_keeps_sr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resv_flag |=> $stable(sr_out));
   p_busy_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rd_req && !ill_flag && !resv_flag);
   p_busy_keeps_sr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(sr_out));
endmodule

bind cdx_core cdx_core_chk #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .ill_flag  (ill_flag),
   .resv_flag (resv_flag),
   .rd_req    (rd_req),
   .rd_addr   (rd_addr),
   .sr_out    (sr_out)
);

// File: tb/cdx_core_bench.sv
module cdx_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [15:0] insn = '0;
   logic [31:0] pc = '0;
   logic        busy, ill_flag, resv_flag, rd_req;
   logic [31:0] rd_addr;
   logic [31:0] rd_data = '0;
   logic [3:0]  peek_idx = '0;
   logic [31:0] peek_data, sr_out;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   logic [31:0] exp_r [16];
   logic [31:0] exp_sr;

   always #(CLK_PERIOD/2) clk = ~clk;

   cdx_core u_cdx_core (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn), .pc(pc),
      .busy(busy), .ill_flag(ill_flag), .resv_flag(resv_flag), .rd_req(rd_req),
      .rd_addr(rd_addr), .rd_data(rd_data), .peek_idx(peek_idx),
      .peek_data(peek_data), .sr_out(sr_out)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {a[15:0], ~a[15:0]} ^ 32'h5A3C_0000;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic peek(input int idx, output logic [31:0] v);
      peek_idx = 4'(idx);
      #1;
      v = peek_data;
   endtask

   task automatic do_reset;
      logic [31:0] v;
      insn_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) exp_r[i] = '0;
      exp_sr = 32'h4000_0000;
      #1;
      for (int i = 0; i < 16; i++) begin
         peek(i, v);
         chk("R1 register after reset", v, 32'h0);
      end
      chk("R1 status after reset", sr_out, 32'h4000_0000);
      chk("R1 busy after reset", {31'b0, busy}, 32'h0);
      chk("R1 rd_req after reset", {31'b0, rd_req}, 32'h0);
      chk("R1 flags after reset", {30'b0, ill_flag, resv_flag}, 32'h0);
   endtask

   // Reference: each outcome derived from the encoding rules of the requirements.
   task automatic exec(input logic [15:0] w, input logic [31:0] pcv, input bit poke);
      logic [3:0]  op, n, m, lo4;
      logic [7:0]  lo8;
      logic        md, e_ill, e_resv, e_req, e_we;
      logic [31:0] e_val, e_addr, v, new_sr;
      string       tg;
      op = w[15:12]; n = w[11:8]; m = w[7:4]; lo8 = w[7:0]; lo4 = w[3:0];
      md = exp_sr[30];
      e_ill = 0; e_resv = 0; e_req = 0; e_we = 0; e_val = '0;
      new_sr = exp_sr; e_addr = '0; tg = "R10";
      case (op)
         4'h0: begin
            if (lo8 == 8'h02) begin
               if (md) begin e_we = 1; e_val = exp_sr; tg = "R6"; end
               else begin e_resv = 1; tg = "R8"; end
            end else if (lo8 == 8'h09) begin
               tg = "R9";
               if (n != 0) e_ill = 1;
            end else e_ill = 1;
         end
         4'h2: if (lo4 == 4'hB) begin
                  e_we = 1; e_val = exp_r[n] | exp_r[m]; tg = "R4";
               end else e_ill = 1;
         4'h4: begin
            if (lo8 == 8'h00) begin
               e_we = 1; e_val = {exp_r[n][30:0], 1'b0};
               new_sr[0] = exp_r[n][31]; tg = "R5";
            end else if (lo8 == 8'h0E) begin
               if (md) begin new_sr = exp_r[n]; tg = "R7"; end
               else begin e_resv = 1; tg = "R8"; end
            end else e_ill = 1;
         end
         4'h6: if (lo4 == 4'h3) begin
                  e_we = 1; e_val = exp_r[m]; tg = "R2";
               end else e_ill = 1;
         4'hD: begin
            e_req = 1; tg = "R11";
            e_addr = {pcv[31:2], 2'b00} + 32'd4 + {22'b0, lo8, 2'b00};
            e_we = 1; e_val = mem_word(e_addr);
         end
         4'hE: begin
            e_we = 1; e_val = {{24{lo8[7]}}, lo8}; tg = "R3";
         end
         default: e_ill = 1;
      endcase

      @(negedge clk);
      insn = w; pc = pcv; insn_valid = 1'b1;
      #1;
      chk({tg, " ill_flag"}, {31'b0, ill_flag}, {31'b0, e_ill});
      chk({tg, " resv_flag"}, {31'b0, resv_flag}, {31'b0, e_resv});
      chk({tg, " rd_req"}, {31'b0, rd_req}, {31'b0, e_req});
      if (e_req) chk("R11 rd_addr", rd_addr, e_addr);
      @(posedge clk);
      #1;
      if (poke) begin
         insn = 16'hE9AA; insn_valid = 1'b1;
      end else insn_valid = 1'b0;
      if (e_req) begin
         rd_data = e_val;
         chk("R11 busy during wait", {31'b0, busy}, 32'h1);
         if (poke) begin
            chk("R12 flags quiet while busy", {29'b0, ill_flag, resv_flag, rd_req}, 32'h0);
         end
         @(posedge clk);
         #1;
         insn_valid = 1'b0;
         chk("R11 busy released", {31'b0, busy}, 32'h0);
      end
      if (e_we) exp_r[n] = e_val;
      exp_sr = new_sr;
      peek(int'(n), v);
      chk({tg, " destination register"}, v, exp_r[n]);
      chk({tg, " status word"}, sr_out, exp_sr);
      if (poke) begin
         peek(9, v);
         chk("R12 ignored instruction while busy", v, exp_r[9]);
      end
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      do_reset();
      // Directed cases
      exec(16'hE180, 32'h100, 0);      // R3 negative immediate
      exec(16'hE27F, 32'h102, 0);      // R3 positive immediate
      exec(16'h6313, 32'h104, 0);      // R2 copy
      exec(16'h221B, 32'h106, 0);      // R4 or
      exec(16'h4200, 32'h108, 0);      // R5 shift, T set
      exec(16'hE401, 32'h10A, 0);
      exec(16'h4400, 32'h10C, 0);      // R5 shift, T cleared
      exec(16'h0502, 32'h10E, 0);      // R6 status to register
      exec(16'hE701, 32'h110, 0);
      exec(16'h257B, 32'h112, 0);
      exec(16'h450E, 32'h114, 0);      // R7 register to status
      exec(16'h0009, 32'h116, 0);      // R9 plain no-op
      exec(16'h0109, 32'h118, 0);      // R9 malformed no-op
      exec(16'h1234, 32'h11A, 0);      // R10 unknown
      exec(16'hDA05, 32'h0000_2003, 1);// R11 load, R12 busy poke
      exec(16'hDBFF, 32'hFFFF_FFFE, 0);// R11 address wrap
      exec(16'hE800, 32'h120, 0);
      exec(16'h480E, 32'h122, 0);      // clears privilege bit
      exec(16'h0302, 32'h124, 0);      // R8 refused status read
      exec(16'h420E, 32'h126, 0);      // R8 refused status write
      // Exhaustive sweep of every halfword
      do_reset();
      for (int w = 0; w < 65536; w++) begin
         exec(16'(w), 32'h1234_0000 ^ (32'(w) * 32'd7), 0);
      end
      report();
   end
endmodule